// File: doc/BRIEF.md
# Byte-Masked Streaming Store Unit

This block carries out a store in which every byte of a 64-bit value is written to memory only when a second 64-bit operand allows it. The enable for each byte comes from the top bit of the matching byte of that second operand. Disabled bytes leave memory untouched. The destination address does not come from an encoded memory operand. It comes from a 32-bit index-register value that the surrounding pipeline supplies with the operands. The store does not go through the cache: it is sent as one transaction on a plain write port with address, data, byte strobes and a valid/ready handshake.

A start pulse brings in the operands, the secondary opcode byte and the two-bit addressing-mode field of the instruction. Only the register-to-register form is legal, and only with the expected opcode byte. Any other form is rejected with an illegal pulse and issues nothing. A legal operation reports completion with a one-cycle done pulse once the memory port has accepted its write. When the memory port accepts at once, done comes two clocks after start. If no byte is enabled, no transaction is issued, but done still arrives after the same two clocks. A start that arrives while an operation is in flight is dropped, and the busy output shows that the unit cannot accept it.

Top module: `masked_store_unit`

## Requirements
- R1: After reset, wr_valid_o, done_o, illegal_o and busy_o are all 0.
- R2: Strobe bit i equals bit 8i+7 of the mask operand and qualifies wr_data_o[8i+7:8i] (byte 0 is the least significant). wr_data_o and wr_addr_o carry the data operand and the destination address as they were at the start edge.
- R3: A legal start with at least one strobe set raises wr_valid_o in the cycle after the edge that samples start_i.
- R4: While wr_valid_o is 1 and wr_ready_i is 0, wr_valid_o stays 1 and address, data and strobes stay unchanged.
- R5: done_o is a one-cycle pulse in the cycle after the edge at which wr_valid_o and wr_ready_i are both 1. With wr_ready_i already high, this is two clocks after start.
- R6: When all eight mask sign bits are 0, wr_valid_o never rises, and done_o pulses two clocks after start.
- R7: A start is legal only when op_mod_i is 2'b11 and op_byte_i is 8'hF7. Otherwise illegal_o pulses for one cycle after the start edge, and no write, no done and no busy follow.
- R8: busy_o is 1 from the cycle after a legal start until the operation completes. A start while busy_o is 1 is ignored: it causes no extra write and no illegal pulse.
- R9: Changing the operand inputs after the start edge has no effect on the write in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| op_byte_i | input | 8 | Secondary opcode byte of the instruction |
| op_mod_i | input | 2 | Addressing-mode field; 2'b11 = register form |
| src_data_i | input | 64 | Data operand |
| src_mask_i | input | 64 | Mask operand; sign bit of each byte enables it |
| dst_addr_i | input | 32 | Destination address from the index register |
| busy_o | output | 1 | Operation in flight |
| illegal_o | output | 1 | One-cycle pulse for a rejected encoding |
| done_o | output | 1 | One-cycle completion pulse |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Memory port accepts the write |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 64 | Write data |
| wr_strb_o | output | 8 | Per-byte write enables |

## Verification
The main function is exercised with a full mask, with a mask in which bytes have their low seven bits set but their sign bit clear, and with a single enabled byte walked across all eight lanes. Together these show whether only the sign bit is used and whether each strobe stays in its own lane. Masks with no sign bit set check that no transaction is issued while done keeps its latency. Different ready delays, operand changes during the wait and a start request during the wait check that the payload is held, that done is tied to acceptance, and that a second start is dropped. Wrong mode fields and a wrong opcode byte check the reject path.

// File: rtl/mstore_pkg.sv
package mstore_pkg;

    localparam logic [7:0] MST_OPCODE   = 8'hF7;
    localparam logic [1:0] MST_MOD_REG  = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_SKIP  = 2'd2
    } mst_state_e;

endpackage

// File: rtl/mstore_decode.sv
module mstore_decode
    import mstore_pkg::*;
(
    input  logic [7:0] op_byte_i,
    input  logic [1:0] op_mod_i,
    output logic       legal_o
);

    always_comb begin
        legal_o = (op_mod_i == MST_MOD_REG) && (op_byte_i == MST_OPCODE);
    end

endmodule

// File: rtl/mstore_lane_enable.sv
module mstore_lane_enable #(
    parameter int LANES = 8,
    localparam int MASK_W = LANES * 8
) (
    input  logic [MASK_W-1:0] mask_i,
    output logic [LANES-1:0]  strb_o,
    output logic              any_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign strb_o[g] = mask_i[g*8 + 7];
    end

    assign any_o = |strb_o;

endmodule

// File: rtl/mstore_ctrl.sv
module mstore_ctrl
    import mstore_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8,
    localparam int DATA_W = LANES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              legal_i,
    input  logic              any_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [LANES-1:0]  strb_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_ready_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [LANES-1:0]  wr_strb_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              illegal_o
);

    typedef struct packed {
        mst_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  strb;
        logic              done;
        logic              illegal;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.illegal = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (!legal_i) begin
                        r_d.illegal = 1'b1;
                    end else begin
                        r_d.addr  = addr_i;
                        r_d.data  = data_i;
                        r_d.strb  = strb_i;
                        r_d.state = any_i ? ST_WRITE : ST_SKIP;
                    end
                end
            end
            ST_WRITE: begin
                if (wr_ready_i) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            ST_SKIP: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, data: '0, strb: '0,
                     done: 1'b0, illegal: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_valid_o = (r_q.state == ST_WRITE);
    assign wr_addr_o  = r_q.addr;
    assign wr_data_o  = r_q.data;
    assign wr_strb_o  = r_q.strb;
    assign done_o     = r_q.done;
    assign illegal_o  = r_q.illegal;
    assign busy_o     = (r_q.state != ST_IDLE);

    assert_payload_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o)
            && $stable(wr_data_o) && $stable(wr_strb_o));

    assert_no_empty_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> wr_strb_o != '0);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && wr_ready_i |=> done_o && !wr_valid_o);

    assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !busy_o && !done_o && !wr_valid_o);

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> !illegal_o);

endmodule

// File: rtl/masked_store_unit.sv
module masked_store_unit #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 8,
    localparam int DATA_W = LANES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        op_byte_i,
    input  logic [1:0]        op_mod_i,
    input  logic [DATA_W-1:0] src_data_i,
    input  logic [DATA_W-1:0] src_mask_i,
    input  logic [ADDR_W-1:0] dst_addr_i,
    output logic              busy_o,
    output logic              illegal_o,
    output logic              done_o,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [LANES-1:0]  wr_strb_o
);

    logic             legal;
    logic             any_en;
    logic [LANES-1:0] lane_en;

    mstore_decode u_decode (
        .op_byte_i (op_byte_i),
        .op_mod_i  (op_mod_i),
        .legal_o   (legal)
    );

    mstore_lane_enable #(.LANES(LANES)) u_lanes (
        .mask_i (src_mask_i),
        .strb_o (lane_en),
        .any_o  (any_en)
    );

    mstore_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .legal_i    (legal),
        .any_i      (any_en),
        .data_i     (src_data_i),
        .strb_i     (lane_en),
        .addr_i     (dst_addr_i),
        .wr_ready_i (wr_ready_i),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_strb_o  (wr_strb_o),
        .done_o     (done_o),
        .busy_o     (busy_o),
        .illegal_o  (illegal_o)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !wr_valid_o && !done_o && !illegal_o && !busy_o);

endmodule

// File: tb/masked_store_unit_bench.sv
`timescale 1ns/1ps
module masked_store_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opb = 8'h00;
    logic [1:0]  md = 2'b00;
    logic [63:0] data = '0;
    logic [63:0] mask = '0;
    logic [31:0] addr = '0;
    logic        rdy = 1'b0;
    logic        busy, illegal, done, valid;
    logic [31:0] waddr;
    logic [63:0] wdata;
    logic [7:0]  wstrb;

    int n_total = 0;
    int n_fail  = 0;
    logic [103:0] exp_q[$];

    always #10 clk = ~clk;

    masked_store_unit u_masked_store_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_byte_i(opb),
        .op_mod_i(md), .src_data_i(data), .src_mask_i(mask),
        .dst_addr_i(addr), .busy_o(busy), .illegal_o(illegal),
        .done_o(done), .wr_valid_o(valid), .wr_ready_i(rdy),
        .wr_addr_o(waddr), .wr_data_o(wdata), .wr_strb_o(wstrb)
    );

    task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
        n_total++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    function automatic logic [7:0] strb_of(input logic [63:0] m);
        logic [7:0] s;
        for (int i = 0; i < 8; i++) s[i] = m[8*i + 7];
        return s;
    endfunction

    // monitor: compares each accepted write with the scoreboard (R2, R9, R8)
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (valid && rdy) begin
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected write", {32'h0, waddr}, 64'hFFFF_FFFF);
                end else begin
                    logic [103:0] e;
                    e = exp_q.pop_front();
                    chk("R2 address", {32'h0, waddr}, {32'h0, e[103:72]});
                    chk("R2 R9 data", wdata, e[71:8]);
                    chk("R2 strobes", {56'h0, wstrb}, {56'h0, e[7:0]});
                end
            end
        end
    end

    task automatic run_op(input logic [63:0] d, input logic [63:0] m, input logic [31:0] a,
                          input logic [1:0] mode, input logic [7:0] op, input int w,
                          input bit poke);
        logic [7:0] es;
        bit legal;
        es = strb_of(m);
        legal = (mode == 2'b11) && (op == 8'hF7);
        @(negedge clk);
        start = 1'b1; data = d; mask = m; addr = a; md = mode; opb = op;
        rdy = (w == 0);
        if (legal && es != 8'h00) exp_q.push_back({a, d, es});
        @(negedge clk);
        start = 1'b0; data = ~d; mask = ~m; addr = ~a;
        if (!legal) begin
            chk("R7 illegal pulse", {63'h0, illegal}, 64'h1);
            chk("R7 no busy", {63'h0, busy}, 64'h0);
            chk("R7 no write", {63'h0, valid}, 64'h0);
            @(negedge clk);
            chk("R7 illegal ends", {63'h0, illegal}, 64'h0);
            chk("R7 no done", {63'h0, done}, 64'h0);
            rdy = 1'b0;
            return;
        end
        chk("R8 busy after start", {63'h0, busy}, 64'h1);
        if (es == 8'h00) begin
            chk("R6 no valid", {63'h0, valid}, 64'h0);
            @(negedge clk);
            chk("R6 done latency", {63'h0, done}, 64'h1);
            chk("R6 no valid", {63'h0, valid}, 64'h0);
        end else begin
            chk("R3 valid rises", {63'h0, valid}, 64'h1);
            for (int k = 0; k < w; k++) begin
                if (poke && k == 0) begin
                    start = 1'b1; data = 64'hDEAD_BEEF_0BAD_F00D; mask = '1;
                end
                @(negedge clk);
                start = 1'b0;
                chk("R4 valid held", {63'h0, valid}, 64'h1);
                chk("R4 no early done", {63'h0, done}, 64'h0);
                chk("R8 busy held", {63'h0, busy}, 64'h1);
                if (poke && k == 0) chk("R8 no illegal", {63'h0, illegal}, 64'h0);
            end
            rdy = 1'b1;
            @(negedge clk);
            chk("R5 done after accept", {63'h0, done}, 64'h1);
            chk("R5 valid drops", {63'h0, valid}, 64'h0);
            rdy = 1'b0;
        end
        chk("R8 busy clears", {63'h0, busy}, 64'h0);
        @(negedge clk);
        chk("R5 done one cycle", {63'h0, done}, 64'h0);
    endtask

    initial begin
        #(20 * 150000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", {63'h0, valid}, 64'h0);
        chk("R1 done", {63'h0, done}, 64'h0);
        chk("R1 illegal", {63'h0, illegal}, 64'h0);
        chk("R1 busy", {63'h0, busy}, 64'h0);
        rst_n = 1'b1;
        // full mask, ready immediately: two-clock latency (R2 R3 R5)
        run_op(64'h0123_4567_89AB_CDEF, '1, 32'h0000_1000, 2'b11, 8'hF7, 0, 1'b0);
        // sign bits only decide, low bits set elsewhere (R2)
        run_op(64'h1122_3344_5566_7788, 64'h807F_FF00_0180_7EC0, 32'h0000_2008, 2'b11, 8'hF7, 1, 1'b0);
        // walk one enabled byte over all lanes, varying ready delay (R2 R4)
        for (int i = 0; i < 8; i++) begin
            run_op(64'hA5A5_5A5A_C3C3_3C3C ^ 64'(i), 64'h80 << (8*i), 32'h4000 + 32'(i), 2'b11, 8'hF7, i % 3, 1'b0);
        end
        // long wait, operand change and start while busy (R4 R8 R9)
        run_op(64'hFEED_FACE_CAFE_BABE, 64'h8000_8000_8000_8000, 32'hFFFF_FFF8, 2'b11, 8'hF7, 4, 1'b1);
        // no sign bits: no write, done at same latency (R6)
        run_op(64'h5555_5555_5555_5555, 64'h7F7F_7F7F_7F7F_7F7F, 32'h3000, 2'b11, 8'hF7, 0, 1'b0);
        run_op(64'h0, 64'h0, 32'h3008, 2'b11, 8'hF7, 2, 1'b0);
        // rejected encodings (R7)
        run_op(64'h1, '1, 32'h5000, 2'b00, 8'hF7, 0, 1'b0);
        run_op(64'h2, '1, 32'h5008, 2'b10, 8'hF7, 0, 1'b0);
        run_op(64'h3, '1, 32'h5010, 2'b11, 8'hE7, 0, 1'b0);
        // legal again after rejects
        run_op(64'hCAFE_0000_0000_BEEF, 64'h0000_0000_0000_8080, 32'h6000, 2'b11, 8'hF7, 0, 1'b0);
        repeat (2) @(negedge clk);
        chk("R2 all expected writes seen", 64'(exp_q.size()), 64'h0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule